// File: doc/BRIEF.md
# Vector Filter Multiply-Accumulate Engine

The engine runs a fixed-point FIR filter, or an IIR filter in direct form 1, over a stream of 16-bit samples. One signed multiply-accumulate datapath walks through the taps. All operands sit in a single 256-word local memory, which is split by software into three regions:

- a circular input-sample ring;
- a coefficient area;
- a circular output ring.

Samples enter through a write port and are dropped when the ring is full. Results leave through a read port whose valid flag holds a read off until a result exists. Two request lines driven by a shared watermark tell a DMA engine or an interrupt handler when to refill or drain the rings.

Each result is built in several steps. Every product is scaled down by 256 and added to, or subtracted from, a 26-bit accumulator. The sum is then rounded, arithmetically shifted by a programmable amount, and clipped to 16 bits. When no full sample window is present, or the output ring has no free slot, the engine waits in its idle state and resumes without help. Sticky flags record clipping, input overflow and output underflow.

The register handshake is one write strobe with a 4-bit address. The map is:

| Address | Register |
|---|---|
| 0 | Input ring base |
| 1 | Input ring size |
| 2 | Coefficient base |
| 3 | Output ring base |
| 4 | Output ring size |
| 5 | Feed-forward tap count P |
| 6 | Feedback tap count Q |
| 7 | Output shift |
| 8 | Watermark |
| 9 | Memory pointer |
| 10 | Control: bit0 run, bit1 IIR |
| 11 | Memory data: writes `mem[pointer]`, then increments the pointer |

Top module: `vfmac`

## Requirements
- R1: After reset, out_valid, out_req, in_req, busy, sat_flag, ovf_err and udf_err are all 0.
- R2: In FIR mode (control bit1 = 0) output m is y[n] = sum over k = 0..P-1 of b[k]·x[n-k], where b[k] is the word at coefficient base + k and x is the accepted sample stream. n = m + P - 1, so the first result needs P samples.
- R3: Each product is arithmetically shifted right by 8 and accumulated modulo 2^26. The sum is rounded by adding 2^(s-1) when the shift s is nonzero, shifted right arithmetically by s, and clipped to the range -32768..32767.
- R4: In IIR mode (control bit1 = 1), Q feedback terms a[j]·y[m-j] for j = 1..Q are subtracted after the feed-forward terms, with the same product scaling. a[j] is the word at coefficient base + P + j - 1. A y term from before the first result of the run counts as 0.
- R5: sat_flag becomes 1 when a result is clipped and stays 1 until the control register is written.
- R6: The input ring wraps at its programmed size, and no computation starts while fewer than P unconsumed samples are stored.
- R7: The output ring wraps at its programmed size. When it holds that many unread results the engine waits idle, and it resumes once a result is read, with no result lost or reordered.
- R8: in_req is 1 exactly when (input size − stored samples) ≥ watermark. out_req is 1 exactly when unread results ≥ watermark.
- R9: A sample offered while the input ring is full is dropped and sets ovf_err, which stays 1 until the control register is written.
- R10: A read strobe while out_valid is 0 sets udf_err (sticky until a control write) and does not disturb the output stream.
- R11: Writing the control register empties both rings, restarts the run history, returns the engine to idle and clears sat_flag, ovf_err and udf_err.
- R12: While out_valid is 1 and no read or register write occurs, out_valid stays 1 and out_data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| in_valid | input | 1 | Sample write strobe |
| in_data | input | 16 | Sample value, signed |
| in_req | output | 1 | Input ring has at least watermark free slots |
| out_rd | input | 1 | Result read strobe |
| out_data | output | 16 | Oldest unread result, signed |
| out_valid | output | 1 | At least one unread result |
| out_req | output | 1 | At least watermark unread results |
| busy | output | 1 | A result is being computed |
| sat_flag | output | 1 | Sticky clipping flag |
| ovf_err | output | 1 | Sticky input overflow flag |
| udf_err | output | 1 | Sticky output underflow flag |

## Verification
The properties assume three things about the inputs:

- the three memory regions do not overlap;
- Q is smaller than the output ring size;
- no coefficient is loaded through the memory-data register while a result is waiting to be read.

Without these, out_data could change under a held read. The stimulus loads coefficients only while both rings are empty, places the regions at disjoint bases, and keeps Q at two or fewer against rings of three or more slots. In normal runs it writes samples only while in_req is high with a watermark of at least one, and offers extra samples only in the deliberate overflow case.

// File: rtl/vfmac.sv
module vfmac #(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int ACCW = 26,
  parameter int PSH  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_req,
  input  logic          out_rd,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_req,
  output logic          busy,
  output logic          sat_flag,
  output logic          ovf_err,
  output logic          udf_err
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = AW + 1;
  localparam int RW = ACCW + 1;
  typedef enum logic [1:0] {ST_IDLE, ST_MAC, ST_OUT} st_t;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] x1b, x1s, x2b, yb, ys, np, nq, ptr;
  logic [3:0] sh;
  logic [CW-1:0] wm;
  logic run, iir;
  logic [AW-1:0] x_rd, y_wr, y_rd, y_made;
  logic [CW-1:0] x_cnt, y_cnt, k;
  logic signed [ACCW-1:0] acc;
  st_t st;
  logic sat_q, ovf_q, udf_q;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] v, input logic [AW-1:0] sz);
    return (({1'b0, v} + CW'(1)) >= {1'b0, sz}) ? '0 : v + AW'(1);
  endfunction

  logic ctrl_wr, room, in_acc, pop, cons, fb, hist, go, clip;
  logic [CW-1:0] p_w, nterm, xsum, xidx, wsum, widx, j, yidx;
  logic [DW-1:0] coef, samp, res;
  logic signed [2*DW-1:0] prod;
  logic signed [ACCW-1:0] term, acc_nx;
  logic signed [RW-1:0] rnd, shv;
  logic [RW-DW:0] top;

  assign ctrl_wr = cfg_we && cfg_addr == 4'd10;
  assign room    = x_cnt < {1'b0, x1s};
  assign in_acc  = in_valid && !ctrl_wr && room;
  assign out_valid = y_cnt != '0;
  assign pop     = out_rd && out_valid;
  assign cons    = st == ST_OUT;
  assign p_w     = {1'b0, np};
  assign nterm   = p_w + (iir ? {1'b0, nq} : '0);
  assign fb      = k >= p_w;
  assign go      = run && np != '0 && x_cnt >= p_w && y_cnt < {1'b0, ys};

  assign xsum = {1'b0, x_rd} + p_w - CW'(1) - k;
  assign xidx = (xsum >= {1'b0, x1s}) ? xsum - {1'b0, x1s} : xsum;
  assign wsum = {1'b0, x_rd} + x_cnt;
  assign widx = (wsum >= {1'b0, x1s}) ? wsum - {1'b0, x1s} : wsum;
  assign j    = k - p_w + CW'(1);
  assign yidx = ({1'b0, y_wr} >= j) ? {1'b0, y_wr} - j : {1'b0, y_wr} + {1'b0, ys} - j;
  assign hist = j <= {1'b0, y_made};

  assign coef   = mem[x2b + k[AW-1:0]];
  assign samp   = fb ? (hist ? mem[yb + yidx[AW-1:0]] : '0) : mem[x1b + xidx[AW-1:0]];
  assign prod   = $signed(coef) * $signed(samp);
  assign term   = ACCW'(prod >>> PSH);
  assign acc_nx = fb ? acc - term : acc + term;

  assign rnd  = {acc[ACCW-1], acc} + ((sh != 4'd0) ? (RW'(1) << (sh - 4'd1)) : RW'(0));
  assign shv  = rnd >>> sh;
  assign top  = shv[RW-1:DW-1];
  assign clip = !((&top) || !(|top));
  assign res  = clip ? {shv[RW-1], {(DW-1){~shv[RW-1]}}} : shv[DW-1:0];

  assign out_data = mem[yb + y_rd];
  assign in_req   = ({1'b0, x1s} - x_cnt) >= wm;
  assign out_req  = y_cnt >= wm;
  assign busy     = st != ST_IDLE;
  assign sat_flag = sat_q;
  assign ovf_err  = ovf_q;
  assign udf_err  = udf_q;

  always_ff @(posedge clk) begin
    if (cfg_we && cfg_addr == 4'd11) mem[ptr] <= cfg_wdata;
    if (in_acc) mem[x1b + widx[AW-1:0]] <= in_data;
    if (cons) mem[yb + y_wr] <= res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1b <= '0; x1s <= '0; x2b <= '0; yb <= '0; ys <= '0;
      np <= '0; nq <= '0; ptr <= '0; sh <= '0; wm <= CW'(1);
      run <= 1'b0; iir <= 1'b0;
      x_rd <= '0; y_wr <= '0; y_rd <= '0; y_made <= '0;
      x_cnt <= '0; y_cnt <= '0; k <= '0; acc <= '0;
      st <= ST_IDLE; sat_q <= 1'b0; ovf_q <= 1'b0; udf_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          4'd0:  x1b <= cfg_wdata[AW-1:0];
          4'd1:  x1s <= cfg_wdata[AW-1:0];
          4'd2:  x2b <= cfg_wdata[AW-1:0];
          4'd3:  yb  <= cfg_wdata[AW-1:0];
          4'd4:  ys  <= cfg_wdata[AW-1:0];
          4'd5:  np  <= cfg_wdata[AW-1:0];
          4'd6:  nq  <= cfg_wdata[AW-1:0];
          4'd7:  sh  <= cfg_wdata[3:0];
          4'd8:  wm  <= cfg_wdata[CW-1:0];
          4'd9:  ptr <= cfg_wdata[AW-1:0];
          4'd10: begin run <= cfg_wdata[0]; iir <= cfg_wdata[1]; end
          4'd11: ptr <= ptr + AW'(1);
          default: ;
        endcase
      end
      if (ctrl_wr) begin
        x_rd <= '0; y_wr <= '0; y_rd <= '0; y_made <= '0;
        x_cnt <= '0; y_cnt <= '0; k <= '0; acc <= '0;
        st <= ST_IDLE; sat_q <= 1'b0; ovf_q <= 1'b0; udf_q <= 1'b0;
      end else begin
        x_cnt <= x_cnt + CW'(in_acc) - CW'(cons);
        y_cnt <= y_cnt + CW'(cons) - CW'(pop);
        if (pop) y_rd <= wrap_inc(y_rd, ys);
        if (in_valid && !room) ovf_q <= 1'b1;
        if (out_rd && !out_valid) udf_q <= 1'b1;
        case (st)
          ST_IDLE: if (go) begin
            acc <= '0;
            k <= '0;
            st <= ST_MAC;
          end
          ST_MAC: begin
            acc <= acc_nx;
            k <= k + CW'(1);
            if (k == nterm - CW'(1)) st <= ST_OUT;
          end
          default: begin
            x_rd <= wrap_inc(x_rd, x1s);
            y_wr <= wrap_inc(y_wr, ys);
            if (y_made != '1) y_made <= y_made + AW'(1);
            if (clip) sat_q <= 1'b1;
            st <= ST_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/vfmac_chk.sv
module vfmac_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [3:0]    cfg_addr,
  input logic          out_rd,
  input logic [DW-1:0] out_data,
  input logic          out_valid,
  input logic          busy,
  input logic          sat_flag,
  input logic          ovf_err,
  input logic          udf_err
);
  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_rd && !cfg_we |=> out_valid && $stable(out_data));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err && !(cfg_we && cfg_addr == 4'd10) |=> ovf_err);

  // R10
  udf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_rd && !out_valid && !cfg_we |=> udf_err);

  // R5
  sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !(cfg_we && cfg_addr == 4'd10) |=> sat_flag);

  // R11
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == 4'd10 |=> !ovf_err && !udf_err && !sat_flag && !out_valid && !busy);
endmodule

bind vfmac vfmac_chk #(.DW(DW)) u_vfmac_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .out_rd(out_rd),
  .out_data(out_data), .out_valid(out_valid), .busy(busy), .sat_flag(sat_flag),
  .ovf_err(ovf_err), .udf_err(udf_err)
);

// File: tb/test_vfmac.sv
module test_vfmac;
  localparam int PERIOD = 10;
  localparam int X1B = 0, X2B = 64, YB = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic out_rd = 1'b0;
  logic in_req, out_valid, out_req, busy, sat_flag, ovf_err, udf_err;
  logic [15:0] out_data;

  vfmac i_vfmac (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data), .in_req(in_req),
    .out_rd(out_rd), .out_data(out_data), .out_valid(out_valid), .out_req(out_req),
    .busy(busy), .sat_flag(sat_flag), .ovf_err(ovf_err), .udf_err(udf_err));

  always #(PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int xs[$], ys[$], expq[$];
  int bco[256];
  int p_m = 0, q_m = 0, sh_m = 0, iir_m = 0, run_m = 0, x1s_m = 0, cnt_m = 0;
  bit ovf_m = 0, udf_m = 0, sat_m = 0, mon_on = 0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (mon_on) begin
      #1;
      chk("R9 ovf_err per clock", int'(ovf_err), int'(ovf_m));
      chk("R10 udf_err per clock", int'(udf_err), int'(udf_m));
    end
  end

  initial begin
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic int model_y(int n, int m);
    logic signed [25:0] acc;
    int pr, r, yv;
    acc = '0;
    for (int k = 0; k < p_m; k++) begin
      pr = bco[k] * xs[n-k];
      acc = acc + 26'(pr >>> 8);
    end
    if (iir_m != 0)
      for (int jj = 1; jj <= q_m; jj++) begin
        yv = (m - jj >= 0) ? ys[m-jj] : 0;
        pr = bco[p_m+jj-1] * yv;
        acc = acc - 26'(pr >>> 8);
      end
    r = int'(acc);
    if (sh_m != 0) r = r + (1 << (sh_m - 1));
    r = r >>> sh_m;
    if (r > 32767) begin r = 32767; sat_m = 1; end
    if (r < -32768) begin r = -32768; sat_m = 1; end
    return r;
  endfunction

  task automatic cfg(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
    if (a == 10) begin
      ovf_m = 0; udf_m = 0; sat_m = 0; cnt_m = 0;
      xs.delete(); ys.delete(); expq.delete();
      run_m = d & 1; iir_m = (d >> 1) & 1;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setc(int idx, int v);
    bco[idx] = v;
    cfg(9, X2B + idx);
    cfg(11, v);
  endtask

  task automatic setup(int p, int q, int sh, int iir, int x1s, int ysz, int wm);
    p_m = p; q_m = q; sh_m = sh; x1s_m = x1s;
    cfg(0, X1B); cfg(1, x1s); cfg(2, X2B); cfg(3, YB); cfg(4, ysz);
    cfg(5, p); cfg(6, q); cfg(7, sh); cfg(8, wm);
  endtask

  task automatic push(int v, bit wait_req);
    int y;
    @(negedge clk);
    if (wait_req)
      for (int t = 0; t < 3000 && !in_req; t++) @(negedge clk);
    in_valid = 1'b1; in_data = 16'(v);
    if (wait_req || cnt_m < x1s_m) begin
      xs.push_back(v); cnt_m++;
      if (run_m != 0 && xs.size() >= p_m) begin
        y = model_y(xs.size() - 1, ys.size());
        ys.push_back(y); expq.push_back(y);
      end
    end else ovf_m = 1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic read_one(string req);
    int e;
    for (int t = 0; t < 3000 && !out_valid; t++) @(negedge clk);
    e = (expq.size() != 0) ? expq.pop_front() : 99999;
    chk(req, int'($signed(out_data)), e);
    out_rd = 1'b1;
    @(negedge clk);
    out_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_req", int'(out_req), 0);
    chk("R1 in_req", int'(in_req), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 sat_flag", int'(sat_flag), 0);
    chk("R1 ovf_err", int'(ovf_err), 0);
    chk("R1 udf_err", int'(udf_err), 0);
    rst_n = 1'b1;
    mon_on = 1;

    // R2 R3 R6: FIR, three taps, shift 1, input ring of 4 that wraps
    setup(3, 0, 1, 0, 4, 16, 1);
    setc(0, 300); setc(1, -200); setc(2, 100);
    cfg(10, 1);
    push(1500, 1); push(-700, 1);
    repeat (20) @(negedge clk);
    chk("R6 no result before P samples", int'(out_valid), 0);
    chk("R6 idle before P samples", int'(busy), 0);
    for (int i = 0; i < 12; i++) push((i * 1237) % 4000 - 2000, 1);
    for (int i = 0; i < 12; i++) read_one("R2 FIR result");
    chk("R5 no clipping in FIR run", int'(sat_flag), int'(sat_m));

    // R3: rounding with shift 3
    setup(2, 0, 3, 0, 8, 16, 1);
    setc(0, 1000); setc(1, 777);
    cfg(10, 1);
    for (int i = 0; i < 8; i++) push(i * 311 - 1200, 1);
    for (int i = 0; i < 7; i++) read_one("R3 rounded result");

    // R5: clipping both signs
    setup(3, 0, 0, 0, 8, 16, 1);
    setc(0, 32767); setc(1, 32767); setc(2, 32767);
    cfg(10, 1);
    for (int i = 0; i < 8; i++) push((i < 4) ? 32000 : -32000, 1);
    for (int i = 0; i < 6; i++) read_one("R5 clipped result");
    chk("R5 sat_flag set", int'(sat_flag), int'(sat_m));

    // R4: IIR direct form 1
    setup(2, 2, 0, 1, 8, 16, 1);
    setc(0, 128); setc(1, 64); setc(2, -100); setc(3, 50);
    cfg(10, 3);
    for (int i = 0; i < 12; i++) push((i % 3) * 4000 - 3000, 1);
    for (int i = 0; i < 11; i++) read_one("R4 IIR result");

    // R7 R8 R12: output ring full stall
    setup(1, 0, 0, 0, 8, 3, 3);
    setc(0, 256);
    cfg(10, 1);
    for (int i = 0; i < 6; i++) push(i * 100 + 7, 1);
    repeat (60) @(negedge clk);
    chk("R8 out_req at watermark", int'(out_req), 1);
    chk("R8 in_req free slots", int'(in_req), 1);
    chk("R7 stalled idle", int'(busy), 0);
    chk("R12 held data", int'($signed(out_data)), expq[0]);
    repeat (5) @(negedge clk);
    chk("R12 data still held", int'($signed(out_data)), expq[0]);
    for (int i = 0; i < 6; i++) read_one("R7 result after stall");

    // R9 R8 R10 R11: overflow with engine stopped, then underflow, then clear
    setup(1, 0, 0, 0, 4, 4, 1);
    cfg(10, 0);
    for (int i = 0; i < 4; i++) push(i, 0);
    @(negedge clk);
    chk("R8 in_req low when full", int'(in_req), 0);
    push(55, 0);
    chk("R9 ovf_err set", int'(ovf_err), 1);
    @(negedge clk);
    out_rd = 1'b1; udf_m = 1;
    @(negedge clk);
    out_rd = 1'b0;
    chk("R10 udf_err set", int'(udf_err), 1);
    chk("R10 out_valid unchanged", int'(out_valid), 0);
    cfg(10, 0);
    chk("R11 ovf cleared", int'(ovf_err), 0);
    chk("R11 udf cleared", int'(udf_err), 0);
    chk("R11 in_req after clear", int'(in_req), 1);

    repeat (3) @(negedge clk);
    mon_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule